// File: doc/BRIEF.md
# Masked Three-Line Interrupt Concentrator

This block gathers up to 96 event flags into three 32-bit pending words and drives three level-sensitive interrupt request lines toward a processor. Each request line has its own bank of three 32-bit enable words. A line is raised while at least one pending flag is also enabled in that line's bank. The line falls once no such flag remains.

Hardware sources set pending flags through a 96-bit event input. Software reaches the pending and enable words through a simple single-cycle register port. Reads have no side effects. A software write to a pending word normally acknowledges, which means it clears flags. Setting bit 32 of the 33-bit write data turns the write into a set instead. The request lines are registered, so they follow the stored state with one cycle of latency.

Top module: `irq_concentrator`

## Requirements
- R1: After reset every pending and enable word reads as zero and all three request lines are low.
- R2: Request line k is high in a cycle exactly when, in the previous cycle, some pending word ANDed with line k's enable word of the same index was nonzero.
- R3: The word index is address bits [3:2]. Pending words sit at byte offsets 0x00, 0x04 and 0x08. The enable words of line 0 sit at 0x10, 0x14 and 0x18. Those of line 1 sit at 0x20, 0x24 and 0x28. Those of line 2 sit at 0x30, 0x34 and 0x38.
- R4: A write to a pending word with data bit 32 low clears each flag whose data bit is 1 and leaves every other flag unchanged.
- R5: A write to a pending word with data bit 32 high ORs data bits [31:0] into that word.
- R6: A write to an enable word replaces it with data bits [31:0]. A read of any mapped word returns its stored value unchanged.
- R7: Each event input bit sampled high at a clock edge sets the matching pending flag (event bit 32*w+b maps to pending word w, bit b). When a software clear and an event hit the same flag in the same cycle, the flag ends up set.
- R8: These offsets are unmapped: any offset with index 3 (0x0C, 0x1C, 0x2C, 0x3C), any offset with bits [1:0] nonzero, and any offset at or above 0x40. Reads of them return zero. Writes to them change no state.
- R9: A write that changes an enable or pending word moves the affected request line on the second clock edge after the write is presented: the line is unchanged right after the write edge and updated one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 33 | Write data; bit 32 selects set mode for pending words |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_in | input | 96 | Hardware event flags, one per pending bit |
| irq_out | output | 3 | Level-sensitive interrupt request lines |

## Verification
The bound checker checks five things on every cycle: that each request line tracks the enabled-pending product of the previous cycle, that sampled events always land in the pending words, that a clear-mode write never raises a flag, that unmapped writes leave every word untouched, and that unmapped reads return zero. The bench scenarios cover the behaviour that needs an address map and a data model. This includes the exact placement of each word, set-mode ORing against clear-mode masking, the set-over-clear race on one flag, and the one-edge delay between an enable write and the line it drives. These are compared against a bench-side model under random and directed traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Fields of a decoded register-port offset.
  typedef struct packed {
    logic       hit;     // offset maps to a stored word
    logic [1:0] region;  // 0: pending, 1..3: enable bank of line region-1
    logic [1:0] idx;     // word index inside the region
  } irqc_dec_t;

  localparam logic [1:0] REGION_PEND = 2'd0;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_WORDS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output irqc_dec_t         dec
);
  logic upper_zero;
  logic aligned;
  logic idx_ok;

  always_comb begin
    upper_zero = ((addr >> 6) == '0);
    aligned    = (addr[1:0] == 2'b00);
    idx_ok     = (32'(addr[3:2]) < N_WORDS);
    dec.hit    = upper_zero && aligned && idx_ok;
    dec.region = addr[5:4];
    dec.idx    = idx_ok ? addr[3:2] : 2'd0;
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 3,
  localparam int TOT    = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [1:0]        sw_idx,
  input  logic              sw_set_mode,
  input  logic [WORD_W-1:0] sw_data,
  input  logic [TOT-1:0]    evt,
  output logic [TOT-1:0]    pend_flat
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] clr_bits;
    logic [WORD_W-1:0] set_bits;
    logic [WORD_W-1:0] evt_bits;
    logic              sel;
    logic              en;

    always_comb begin
      sel      = sw_wr && (sw_idx == 2'(w));
      clr_bits = (sel && !sw_set_mode) ? sw_data : '0;
      set_bits = (sel &&  sw_set_mode) ? sw_data : '0;
      evt_bits = evt[w*WORD_W +: WORD_W];
      word_d   = (word_q & ~clr_bits) | set_bits | evt_bits;
      en       = sel || (|evt_bits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (en) word_q <= word_d;
    end

    assign pend_flat[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 3,
  localparam int TOT    = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        idx,
  input  logic [WORD_W-1:0] data,
  output logic [TOT-1:0]    mask_flat
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              en;

    always_comb en = wr && (idx == 2'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (en) word_q <= data;
    end

    assign mask_flat[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/irqc_line_eval.sv
module irqc_line_eval #(
  parameter int TOT    = 96,
  parameter int N_OUTS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TOT-1:0]              pend_flat,
  input  logic [N_OUTS-1:0][TOT-1:0]  mask_flat,
  output logic [N_OUTS-1:0]           line_q
);
  logic [N_OUTS-1:0] line_d;

  always_comb begin
    for (int o = 0; o < N_OUTS; o++) begin
      line_d[o] = |(pend_flat & mask_flat[o]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irqc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 3,
  parameter int N_OUTS  = 3,
  parameter int ADDR_W  = 8,
  localparam int TOT    = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W:0]   bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [TOT-1:0]    evt_in,
  output logic [N_OUTS-1:0] irq_out
);
  // Asynchronous assertion, synchronous release.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  irqc_dec_t dec;

  irqc_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_decode (
    .addr (bus_addr),
    .dec  (dec)
  );

  logic              pend_wr;
  logic [TOT-1:0]    pend_flat;

  always_comb pend_wr = bus_we && dec.hit && (dec.region == REGION_PEND);

  irqc_pending #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_pending (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sw_wr       (pend_wr),
    .sw_idx      (dec.idx),
    .sw_set_mode (bus_wdata[WORD_W]),
    .sw_data     (bus_wdata[WORD_W-1:0]),
    .evt         (evt_in),
    .pend_flat   (pend_flat)
  );

  logic [N_OUTS-1:0][TOT-1:0] mask_flat;

  for (genvar o = 0; o < N_OUTS; o++) begin : g_bank
    logic bank_wr;
    always_comb bank_wr = bus_we && dec.hit && (dec.region == 2'(o + 1));

    irqc_mask_bank #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr        (bank_wr),
      .idx       (dec.idx),
      .data      (bus_wdata[WORD_W-1:0]),
      .mask_flat (mask_flat[o])
    );
  end

  irqc_line_eval #(.TOT(TOT), .N_OUTS(N_OUTS)) u_eval (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pend_flat (pend_flat),
    .mask_flat (mask_flat),
    .line_q    (irq_out)
  );

  // Read path: side-effect free, zero for unmapped offsets.
  always_comb begin
    bus_rdata = '0;
    if (dec.hit) begin
      if (dec.region == REGION_PEND) begin
        bus_rdata = pend_flat[32'(dec.idx)*WORD_W +: WORD_W];
      end else if (32'(dec.region) <= N_OUTS) begin
        bus_rdata = mask_flat[2'(dec.region - 2'd1)][32'(dec.idx)*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 3,
  parameter int N_OUTS  = 3,
  parameter int ADDR_W  = 8,
  localparam int TOT    = WORD_W * N_WORDS
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [WORD_W:0]            bus_wdata,
  input logic [WORD_W-1:0]          bus_rdata,
  input logic [TOT-1:0]             evt_in,
  input logic [N_OUTS-1:0]          irq_out,
  input logic [TOT-1:0]             pend_flat,
  input logic [N_OUTS-1:0][TOT-1:0] mask_flat
);
  logic              mapped;
  logic              past_ok;
  logic [TOT-1:0]    evt_q;
  logic [N_OUTS-1:0] prod_q;

  always_comb mapped = ((bus_addr >> 6) == '0) && (bus_addr[1:0] == 2'b00)
                       && (32'(bus_addr[3:2]) < N_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      evt_q   <= '0;
      prod_q  <= '0;
    end else begin
      past_ok <= 1'b1;
      evt_q   <= evt_in;
      for (int o = 0; o < N_OUTS; o++) prod_q[o] <= |(pend_flat & mask_flat[o]);
    end
  end

  AST_LINE_TRACKS_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_out == prod_q)); // R2

  AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_flat & evt_q) == evt_q)); // R7

  AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && mapped && (bus_addr[5:4] == 2'd0) && !bus_wdata[WORD_W] && (evt_in == '0))
    |=> ((pend_flat & ~$past(pend_flat)) == '0)); // R4

  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !mapped && (evt_in == '0)) |=> ($stable(pend_flat) && $stable(mask_flat))); // R8

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == '0)); // R8
endmodule

bind irq_concentrator irqc_checker #(
  .WORD_W(WORD_W), .N_WORDS(N_WORDS), .N_OUTS(N_OUTS), .ADDR_W(ADDR_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .evt_in    (evt_in),
  .irq_out   (irq_out),
  .pend_flat (pend_flat),
  .mask_flat (mask_flat)
);

// File: tb/tb_irq_concentrator.sv
module tb_irq_concentrator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [32:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [95:0] evt_in;
  logic [2:0]  irq_out;

  always #5 clk = ~clk;

  irq_concentrator dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq_out(irq_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] pend_m [3];
  logic [31:0] mask_m [3][3];

  task automatic chk(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(logic [7:0] a);
    return (a[7:6] == 2'b00) && (a[1:0] == 2'b00) && (a[3:2] != 2'd3);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (!m_hit(a)) return 32'h0;
    if (a[5:4] == 2'd0) return pend_m[a[3:2]];
    return mask_m[a[5:4]-2'd1][a[3:2]];
  endfunction

  function automatic logic [2:0] m_irq();
    logic [2:0] r = '0;
    for (int o = 0; o < 3; o++)
      for (int w = 0; w < 3; w++)
        if ((pend_m[w] & mask_m[o][w]) != 0) r[o] = 1'b1;
    return r;
  endfunction

  // One clock with optional write and events; checks the request lines.
  task automatic step(bit we, logic [7:0] a, logic [32:0] d, logic [95:0] ev, string tag);
    logic [2:0] exp_irq;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; evt_in = ev;
    exp_irq = m_irq();
    if (we && m_hit(a)) begin
      if (a[5:4] == 2'd0) begin
        if (d[32]) pend_m[a[3:2]] = pend_m[a[3:2]] | d[31:0];
        else       pend_m[a[3:2]] = pend_m[a[3:2]] & ~d[31:0];
      end else begin
        mask_m[a[5:4]-2'd1][a[3:2]] = d[31:0];
      end
    end
    for (int w = 0; w < 3; w++) pend_m[w] = pend_m[w] | ev[w*32 +: 32];
    @(posedge clk);
    #1;
    chk(irq_out == exp_irq, tag, 96'(irq_out), 96'(exp_irq));
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a; evt_in = '0;
    #1;
    chk(bus_rdata == m_read(a), tag, 96'(bus_rdata), 96'(m_read(a)));
  endtask

  task automatic idle(string tag);
    step(1'b0, 8'h00, 33'h0, 96'h0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin : main
    logic [7:0] a;
    logic [7:0] mapped_list [12];
    void'($urandom(32'd1913));
    for (int w = 0; w < 3; w++) begin
      pend_m[w] = '0;
      for (int o = 0; o < 3; o++) mask_m[o][w] = '0;
    end
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 3; w++) mapped_list[r*3+w] = 8'(r*16 + w*4);

    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: everything zero after reset
    #1 chk(irq_out == 3'b000, "R1", 96'(irq_out), 96'h0);
    for (int i = 0; i < 12; i++) rd(mapped_list[i], "R1");

    // R3/R6: enable word of line 0, index 1
    step(1'b1, 8'h14, {1'b0, 32'h0000_00F0}, 96'h0, "R2");
    rd(8'h14, "R6");
    rd(8'h24, "R3");
    // R5: set mode ORs into pending word 1
    step(1'b1, 8'h04, {1'b1, 32'h0000_0010}, 96'h0, "R2");
    chk(irq_out == 3'b000, "R9", 96'(irq_out), 96'h0);
    idle("R9");
    chk(irq_out == 3'b001, "R9", 96'(irq_out), 96'h1);
    rd(8'h04, "R5");
    step(1'b1, 8'h04, {1'b1, 32'h8000_0001}, 96'h0, "R5");
    rd(8'h04, "R5");
    // R4: clear only the ones in the data
    step(1'b1, 8'h04, {1'b0, 32'h0000_0010}, 96'h0, "R4");
    rd(8'h04, "R4");
    idle("R2");
    chk(irq_out == 3'b000, "R4", 96'(irq_out), 96'h0);
    // R7: event beats a clear of the same flag
    step(1'b1, 8'h08, {1'b0, 32'hFFFF_FFFF}, 96'(1) << 69, "R7");
    rd(8'h08, "R7");
    chk(bus_rdata == 32'h20, "R7", 96'(bus_rdata), 96'h20);
    // R9: enable line 2 on word 2 bit 5
    step(1'b1, 8'h38, {1'b0, 32'h0000_0020}, 96'h0, "R9");
    chk(irq_out[2] == 1'b0, "R9", 96'(irq_out), 96'h0);
    idle("R9");
    chk(irq_out[2] == 1'b1, "R9", 96'(irq_out), 96'h4);
    // R8: unmapped writes and reads
    step(1'b1, 8'h0C, {1'b1, 32'hFFFF_FFFF}, 96'h0, "R8");
    step(1'b1, 8'h1C, {1'b0, 32'hFFFF_FFFF}, 96'h0, "R8");
    step(1'b1, 8'h11, {1'b0, 32'hFFFF_FFFF}, 96'h0, "R8");
    step(1'b1, 8'h50, {1'b1, 32'hFFFF_FFFF}, 96'h0, "R8");
    rd(8'h0C, "R8"); rd(8'h3C, "R8"); rd(8'h12, "R8"); rd(8'h90, "R8");
    for (int i = 0; i < 12; i++) rd(mapped_list[i], "R8");

    // Random traffic
    for (int it = 0; it < 600; it++) begin
      logic [95:0] ev;
      ev = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
         & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      if ($urandom_range(0, 3) != 0) ev = '0;
      if ($urandom_range(0, 7) == 0) a = 8'($urandom);
      else a = mapped_list[$urandom_range(0, 11)];
      step($urandom_range(0, 3) != 0, a,
           {1'($urandom), ($urandom_range(0, 1) == 1) ? $urandom : ($urandom & $urandom & $urandom)},
           ev, "R2");
      rd($urandom_range(0, 1) == 1 ? mapped_list[$urandom_range(0, 11)] : 8'($urandom), "R6");
    end
    for (int i = 0; i < 12; i++) rd(mapped_list[i], "R3");

    finished = 1'b1;
    summary();
  end
endmodule